// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the register file of an interrupt redirection unit. A 32-bit bus sees only two locations: a select register and a data window. Software first writes a register number into the select location. Reads and writes at the window location then reach the register that was selected. Behind the window sit the following registers:

- a 4-bit identifier;
- a constant version word;
- an arbitration alias of the identifier;
- a table of redirection entries, each 64 bits wide and reached as a low half and a high half.

Every table entry is driven out continuously on a flat parallel bus for the delivery logic. The delivery logic owns two status bits in each entry: a delivery-pending flag (bit 12) and a level-acknowledge flag (bit 14). It sets and clears them through dedicated per-entry pulse ports. The bus can never write either bit.

The bus side has no back-pressure. Every request is taken in the cycle it is presented. Read data returns combinationally in the same cycle, qualified by `bus_rvalid`. The delivery ports are plain per-entry control pulses.

Top module: `irq_redir_regs`

## Requirements
- R1: An access is acted on only when `bus_valid` is high, `bus_size` equals 4 (bytes) and `bus_addr` is 0x00 (select) or 0x10 (window). Any other access changes no state. For any other read, `bus_rvalid` stays 0 and `bus_rdata` is 0. A write never raises `bus_rvalid`.
- R2: A write at 0x00 stores all 32 data bits in the select register. A read at 0x00 returns the stored value. The select register resets to 0.
- R3: The window decodes only bits 7:0 of the select register. For example, a select value of 0x110 reaches the same register as 0x10.
- R4: Select 0x00 is the identifier. A window write keeps data bits 27:24. A window read at select 0x00 or 0x02 returns the identifier in bits 27:24, with every other bit 0. A window write at select 0x02 changes nothing. The identifier resets to 0.
- R5: Select 0x01 always reads 0x0017_0011, and writes to it have no effect.
- R6: Select 0x10+2k reaches the low half (bits 31:0) of entry k, and select 0x11+2k reaches its high half (bits 63:32), for k from 0 to 23. Entry k is driven on `entries_o[64k+63:64k]`.
- R7: A window write to a low half leaves bits 12 and 14 and bits 63:32 unchanged. It sets every other bit of 31:0 to the matching data bit.
- R8: A window write to a high half replaces bits 63:32 and leaves bits 31:0 unchanged.
- R9: After reset every entry holds 0x0000_0000_0001_0000, so it is masked (bit 16 set).
- R10: A window read at any select value outside 0x00–0x02 and 0x10–0x3F returns 0 with `bus_rvalid` high. A window write there changes nothing.
- R11: A pulse on `dstat_set_i[k]` / `dstat_clr_i[k]` sets or clears bit 12 of entry k at the next edge. `rirr_set_i[k]` / `rirr_clr_i[k]` do the same for bit 14. Set wins over clear. These updates apply even when a bus write hits the same entry in the same cycle.
- R12: `bus_rdata` and `bus_rvalid` follow a read request in the same cycle. A window read reflects the select register and table contents as they stand in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not valid |
| bus_rvalid | output | 1 | Read data is valid this cycle |
| dstat_set_i | input | 24 | Per-entry set of delivery-pending bit 12 |
| dstat_clr_i | input | 24 | Per-entry clear of delivery-pending bit 12 |
| rirr_set_i | input | 24 | Per-entry set of level-acknowledge bit 14 |
| rirr_clr_i | input | 24 | Per-entry clear of level-acknowledge bit 14 |
| entries_o | output | 1536 | All table entries, entry k at bits 64k+63:64k |

## Verification
The embedded properties watch several rules on every cycle:

- read validity and the zeroing of ignored reads;
- the constant version word and the zero fields around the identifier;
- the select register holding still when it is not written;
- each entry's status bits surviving bus writes;
- low halves holding across high-half writes;
- the set-over-clear rule on the status ports.

Only the bench scenarios show the rest:

- that the right entry and half are reached for each select value;
- the truncation of select values to eight bits;
- that writes to undefined selects or with a wrong size leave no trace;
- the reset contents of the table.

These are shown through a reference model checked on window reads and on the exported entry bus.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_SELECT = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_WINDOW = 8'h10;
  localparam logic [2:0]        ACC_BYTES  = 3'd4;

  localparam logic [7:0] SEL_IDENT    = 8'h00;
  localparam logic [7:0] SEL_VERSION  = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_TBL_BASE = 8'h10;

  localparam int unsigned BIT_DSTAT = 12;
  localparam int unsigned BIT_RIRR  = 14;

  localparam logic [ENTRY_W-1:0] ENTRY_RST   = 64'h0000_0000_0001_0000;
  localparam logic [DATA_W-1:0]  LO_WR_MASK  = 32'hFFFF_AFFF;

  typedef enum logic [2:0] {
    TGT_IDENT,
    TGT_VERSION,
    TGT_ARB,
    TGT_TABLE,
    TGT_NONE
  } sel_kind_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_redir_pkg::*;
(
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic              win_wr,
  output logic              win_rd
);
  logic ok;
  logic hit_sel;
  logic hit_win;

  always_comb begin
    ok      = valid && (size == ACC_BYTES);
    hit_sel = ok && (addr == OFF_SELECT);
    hit_win = ok && (addr == OFF_WINDOW);
    sel_wr  = hit_sel && write;
    sel_rd  = hit_sel && !write;
    win_wr  = hit_win && write;
    win_rd  = hit_win && !write;
  end
endmodule

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [7:0]       sel8,
  output sel_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  localparam logic [8:0] TBL_END = 9'(16 + 2 * NUM_ENTRIES);

  logic [7:0] off;

  always_comb begin
    off  = sel8 - SEL_TBL_BASE;
    idx  = IDX_W'(off >> 1);
    hi   = sel8[0];
    if (sel8 == SEL_IDENT)        kind = TGT_IDENT;
    else if (sel8 == SEL_VERSION) kind = TGT_VERSION;
    else if (sel8 == SEL_ARB)     kind = TGT_ARB;
    else if (sel8 >= SEL_TBL_BASE && {1'b0, sel8} < TBL_END) kind = TGT_TABLE;
    else                          kind = TGT_NONE;
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               dstat_set,
  input  logic               dstat_clr,
  input  logic               rirr_set,
  input  logic               rirr_clr,
  output logic [ENTRY_W-1:0] entry
);
  logic [ENTRY_W-1:0] nxt;

  always_comb begin
    nxt = entry;
    if (wr_hi) nxt[63:32] = wdata;
    if (wr_lo) nxt[31:0]  = (entry[31:0] & ~LO_WR_MASK) | (wdata & LO_WR_MASK);
    // delivery-side status updates are applied last: they win
    if (dstat_set)      nxt[BIT_DSTAT] = 1'b1;
    else if (dstat_clr) nxt[BIT_DSTAT] = 1'b0;
    if (rirr_set)       nxt[BIT_RIRR]  = 1'b1;
    else if (rirr_clr)  nxt[BIT_RIRR]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) entry <= ENTRY_RST;
    else        entry <= nxt;
  end

  // R7: bus writes never touch the status bits
  p_dstat_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !dstat_set && !dstat_clr) |=> (entry[BIT_DSTAT] == $past(entry[BIT_DSTAT])));
  p_rirr_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !rirr_set && !rirr_clr) |=> (entry[BIT_RIRR] == $past(entry[BIT_RIRR])));
  // R8: a high-half write keeps the low half
  p_hi_keeps_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !dstat_set && !dstat_clr && !rirr_set && !rirr_clr)
      |=> (entry[31:0] == $past(entry[31:0])));
  // R11: set wins, clear clears
  p_dstat_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dstat_set |=> entry[BIT_DSTAT]);
  p_rirr_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_clr && !rirr_set) |=> !entry[BIT_RIRR]);
endmodule

// File: rtl/irq_win_mux.sv
module irq_win_mux
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter logic [DATA_W-1:0] VERSION = 32'h0017_0011,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  sel_kind_e                        kind,
  input  logic [IDX_W-1:0]                 idx,
  input  logic                             hi,
  input  logic [3:0]                       ident,
  input  logic [NUM_ENTRIES*ENTRY_W-1:0]   entries,
  output logic [DATA_W-1:0]                rdata
);
  logic [ENTRY_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (idx == IDX_W'(k)) picked = entries[k*ENTRY_W +: ENTRY_W];
    end
    unique case (kind)
      TGT_IDENT, TGT_ARB: rdata = {4'b0, ident, 24'b0};
      TGT_VERSION:        rdata = VERSION;
      TGT_TABLE:          rdata = hi ? picked[63:32] : picked[31:0];
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter logic [31:0] VERSION     = 32'h0017_0011
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [7:0]                     bus_addr,
  input  logic [2:0]                     bus_size,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           bus_rvalid,
  input  logic [NUM_ENTRIES-1:0]         dstat_set_i,
  input  logic [NUM_ENTRIES-1:0]         dstat_clr_i,
  input  logic [NUM_ENTRIES-1:0]         rirr_set_i,
  input  logic [NUM_ENTRIES-1:0]         rirr_clr_i,
  output logic [NUM_ENTRIES*64-1:0]      entries_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic              sel_wr, sel_rd, win_wr, win_rd;
  logic [DATA_W-1:0] sel_q;
  logic [3:0]        ident_q;
  sel_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic              hi;
  logic [DATA_W-1:0] win_data;

  irq_bus_decode u_bus (
    .valid (bus_valid), .write (bus_write), .addr (bus_addr), .size (bus_size),
    .sel_wr(sel_wr), .sel_rd(sel_rd), .win_wr(win_wr), .win_rd(win_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (win_wr && kind == TGT_IDENT) ident_q <= bus_wdata[27:24];
    end
  end

  irq_sel_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_seldec (
    .sel8(sel_q[7:0]), .kind(kind), .idx(idx), .hi(hi)
  );

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_entry
    logic hit;
    assign hit = win_wr && (kind == TGT_TABLE) && (idx == IDX_W'(k));
    irq_redir_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (hit && !hi),
      .wr_hi    (hit && hi),
      .wdata    (bus_wdata),
      .dstat_set(dstat_set_i[k]),
      .dstat_clr(dstat_clr_i[k]),
      .rirr_set (rirr_set_i[k]),
      .rirr_clr (rirr_clr_i[k]),
      .entry    (entries_o[k*ENTRY_W +: ENTRY_W])
    );
  end

  irq_win_mux #(.NUM_ENTRIES(NUM_ENTRIES), .VERSION(VERSION)) u_mux (
    .kind(kind), .idx(idx), .hi(hi), .ident(ident_q),
    .entries(entries_o), .rdata(win_data)
  );

  always_comb begin
    bus_rvalid = sel_rd || win_rd;
    if (sel_rd)      bus_rdata = sel_q;
    else if (win_rd) bus_rdata = win_data;
    else             bus_rdata = '0;
  end

  // R1: read data only for well-formed reads, zero otherwise
  p_rvalid_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_valid && !bus_write && bus_size == 3'd4));
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == '0));
  // R2: select register only moves on a select write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_size == 3'd4 && bus_addr == OFF_SELECT) |=> $stable(sel_q));
  // R4: identifier read has only bits 27:24 populated
  p_ident_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && bus_addr == OFF_WINDOW && (sel_q[7:0] == SEL_IDENT || sel_q[7:0] == SEL_ARB))
      |-> (bus_rdata[31:28] == 4'b0 && bus_rdata[23:0] == 24'b0));
  // R5: version word is constant
  p_version_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && bus_addr == OFF_WINDOW && sel_q[7:0] == SEL_VERSION) |-> (bus_rdata == VERSION));
  // R6: table index always in range
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TGT_TABLE) |-> (int'(idx) < NUM_ENTRIES));
endmodule

// File: tb/irq_redir_regs_tb.sv
`timescale 1ns/1ps
module irq_redir_regs_tb;
  localparam int N = 24;
  localparam logic [31:0] VER = 32'h0017_0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [N-1:0] dss = '0, dsc = '0, rs = '0, rc = '0;
  logic [N*64-1:0] entries_o;

  always #2.5 clk = ~clk;

  irq_redir_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dstat_set_i(dss), .dstat_clr_i(dsc), .rirr_set_i(rs), .rirr_clr_i(rc),
    .entries_o(entries_o)
  );

  int errors = 0;
  int checks = 0;
  logic [63:0] m_ent [N];
  logic [31:0] m_sel;
  logic [3:0]  m_id;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] win_val();
    logic [7:0] s = m_sel[7:0];
    int k;
    if (s == 8'h00 || s == 8'h02) return {4'b0, m_id, 24'b0};
    if (s == 8'h01) return VER;
    if (s >= 8'h10 && s < 8'h10 + 2*N) begin
      k = (int'(s) - 16) / 2;
      return s[0] ? m_ent[k][63:32] : m_ent[k][31:0];
    end
    return 32'h0;
  endfunction

  function automatic logic [32:0] exp_rd(input logic [7:0] a, input logic [2:0] sz);
    if (sz != 3'd4) return 33'h0;
    if (a == 8'h00) return {1'b1, m_sel};
    if (a == 8'h10) return {1'b1, win_val()};
    return 33'h0;
  endfunction

  task automatic model_commit(input logic v, w, input logic [7:0] a, input logic [2:0] sz,
                              input logic [31:0] d);
    logic [7:0] s = m_sel[7:0];
    if (v && w && sz == 3'd4) begin
      if (a == 8'h00) m_sel = d;
      else if (a == 8'h10) begin
        if (s == 8'h00) m_id = d[27:24];
        else if (s >= 8'h10 && s < 8'h10 + 2*N) begin
          int k = (int'(s) - 16) / 2;
          if (s[0]) m_ent[k][63:32] = d;
          else m_ent[k] = (m_ent[k] & 64'hFFFF_FFFF_0000_5000) | {32'h0, d & 32'hFFFF_AFFF};
        end
      end
    end
    for (int k = 0; k < N; k++) begin
      if (dss[k]) m_ent[k][12] = 1'b1; else if (dsc[k]) m_ent[k][12] = 1'b0;
      if (rs[k])  m_ent[k][14] = 1'b1; else if (rc[k])  m_ent[k][14] = 1'b0;
    end
  endtask

  task automatic check_entries(input string tag);
    logic [N*64-1:0] flat;
    for (int k = 0; k < N; k++) flat[k*64 +: 64] = m_ent[k];
    checks++;
    if (entries_o !== flat) begin
      errors++;
      for (int k = 0; k < N; k++)
        if (entries_o[k*64 +: 64] !== m_ent[k])
          $display("FAIL %s entry %0d actual=%h expected=%h", tag, k, entries_o[k*64 +: 64], m_ent[k]);
    end
  endtask

  task automatic cycle(input logic v, w, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = d;
    #1;
    if (v && !w) check({tag, " read"}, {31'b0, bus_rvalid, bus_rdata}, {31'b0, exp_rd(a, sz)});
    else         check("R1 no rvalid", {63'b0, bus_rvalid}, 64'h0);
    @(posedge clk);
    model_commit(v, w, a, sz, d);
    #1;
    bus_valid = 1'b0; dss = '0; dsc = '0; rs = '0; rc = '0;
    check_entries({tag, " entries"});
  endtask

  task automatic wr_sel(input logic [31:0] s, input string tag);
    cycle(1'b1, 1'b1, 8'h00, 3'd4, s, tag);
  endtask
  task automatic wr_win(input logic [31:0] d, input string tag);
    cycle(1'b1, 1'b1, 8'h10, 3'd4, d, tag);
  endtask
  task automatic rd_win(input string tag);
    cycle(1'b1, 1'b0, 8'h10, 3'd4, 32'h0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) m_ent[k] = 64'h0000_0000_0001_0000;
    m_sel = '0; m_id = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset contents, R2 select reset
    check_entries("R9 reset");
    cycle(1'b1, 1'b0, 8'h00, 3'd4, 0, "R2 select reset");
    rd_win("R4 ident reset");
    for (int k = 0; k < N; k++) begin
      wr_sel(32'(16 + 2*k), "R6 sel lo");
      rd_win("R9 lo reset");
      wr_sel(32'(17 + 2*k), "R6 sel hi");
      rd_win("R9 hi reset");
    end

    // R4 ident and arbitration alias
    wr_sel(32'h0, "R4 sel");
    wr_win(32'hFA5A_5A5A, "R4 write");
    rd_win("R4 read");
    wr_sel(32'h2, "R4 sel arb");
    rd_win("R4 arb read");
    wr_win(32'h0300_0000, "R4 arb write ignored");
    rd_win("R4 arb unchanged");

    // R5 version
    wr_sel(32'h1, "R5 sel");
    wr_win(32'hFFFF_FFFF, "R5 write");
    rd_win("R5 read");

    // R1 malformed accesses
    cycle(1'b1, 1'b1, 8'h00, 3'd2, 32'h11, "R1 short sel write");
    cycle(1'b1, 1'b0, 8'h00, 3'd4, 0, "R1 sel unchanged");
    cycle(1'b1, 1'b0, 8'h04, 3'd4, 0, "R1 bad offset read");
    cycle(1'b1, 1'b0, 8'h10, 3'd1, 0, "R1 short window read");
    cycle(1'b0, 1'b1, 8'h00, 3'd4, 32'h12, "R1 invalid write");

    // R10 undefined selects
    wr_sel(32'h3, "R10 sel");
    wr_win(32'hDEAD_BEEF, "R10 write");
    rd_win("R10 read 03");
    wr_sel(32'h40, "R10 sel 40");
    wr_win(32'h1234_5678, "R10 write 40");
    rd_win("R10 read 40");

    // R7 low write cannot set status bits; R8 high write
    wr_sel(32'h14, "R7 sel");
    wr_win(32'hFFFF_FFFF, "R7 write lo");
    rd_win("R7 read lo");
    wr_sel(32'h15, "R8 sel");
    wr_win(32'hA5C3_0001, "R8 write hi");
    rd_win("R8 read hi");

    // R3 select truncation
    wr_sel(32'h0000_0114, "R3 sel");
    rd_win("R3 aliased read");
    cycle(1'b1, 1'b0, 8'h00, 3'd4, 0, "R2 full select readback");

    // R11 status ports racing a bus write to the same entry
    wr_sel(32'h14, "R11 sel");
    dss[2] = 1'b1; dsc[2] = 1'b1; rs[2] = 1'b1;
    wr_win(32'h0000_0000, "R11 set wins with bus write");
    rd_win("R11 read");
    rc[2] = 1'b1; dsc[2] = 1'b1;
    wr_win(32'hFFFF_FFFF, "R11 clear with bus write");
    rd_win("R11 read cleared");

    // R12 randomized traffic
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 8;
      logic [31:0] d = $urandom;
      dss = N'($urandom & $urandom & $urandom);
      dsc = N'($urandom & $urandom);
      rs  = N'($urandom & $urandom & $urandom);
      rc  = N'($urandom & $urandom);
      case (op)
        0: wr_sel((($urandom % 4 == 0) ? 32'h100 : 32'h0) | ($urandom % 32'h44), "R6 rand sel");
        1, 2, 3: wr_win(d, "R7 rand write");
        4, 5: rd_win("R12 rand read");
        6: cycle(1'b1, 1'b0, 8'h00, 3'd4, 0, "R2 rand sel read");
        default: cycle(1'b1, $urandom % 2 == 1, 8'($urandom), 3'($urandom), d, "R1 rand junk");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule